// File: doc/BRIEF.md
# Frame Clock Phase Alignment Controller

This block keeps a local multiframe counter on the converter clock in phase with an alignment edge. The counter's wrap point is the reference. When an alignment edge is accepted, the block reads the counter and treats that value as a signed phase offset. It compares the size of that offset with a 3-bit tolerance. If the tolerance is exceeded, the block can reload the counter so that the wrap falls on the edge.

The alignment edge comes from one of two sources. In subclass 1 it is an external pulse, which goes through a two-flop synchronizer and a rising-edge detector. In subclass 0 it is an internal reference counter of the same period.

A 4-bit mode field selects the policy:

- single shot after arming
- continuous
- single shot, then monitor only

Processing needs an enable bit. A self-clearing arm bit starts the single-shot policies. The block reports the signed error, a low-side flag and a high-side flag. At each realignment it captures a snapshot of the error and its flags.

Top module: `frame_phase_align`

## Requirements
- R1: While reset is low and on the first cycle after reset, the counter reads 0 and arm, busy, current error, both flags and all snapshot outputs read 0.
- R2: With no realignment, the counter advances by one each clock, modulo 2**PERIOD_W. The wrap output is high exactly when the counter holds 2**PERIOD_W-1.
- R3: A checked edge whose counter value is c gives error e: e = c if c < 2**(PERIOD_W-1), else e = c - 2**PERIOD_W. cur_err_o shows e as 8-bit two's complement. If |e| > tolerance, err_lo_o is set for negative e (edge before the wrap) and err_hi_o for positive e (edge after the wrap); otherwise both flags are 0.
- R4: A realignment happens on a checked edge that is allowed to rotate and whose |e| exceeds the tolerance. On the next cycle the counter reads 1, cur_err_o reads 0 and both flags are clear. When |e| is within the tolerance, the counter keeps counting.
- R5: At a realignment, snap_err_o captures bits [3:0] of e. snap_lo_o and snap_hi_o capture the flags that e produces. Snapshots change at no other time.
- R6: Mode 4'h1 (single shot) checks an edge, and may rotate on it, only while arm is set. Edges accepted while unarmed leave the counter, the error, the flags and the snapshots untouched.
- R7: Mode 4'h2 (continuous) checks every accepted edge and may rotate on it, whether or not arm is set. Arming changes nothing except the arm bit itself.
- R8: Mode 4'h9 (shot then monitor) checks an armed edge and may rotate on it. Unarmed edges update cur_err_o and the flags but never rotate.
- R9: A realignment drives busy_o high for BUSY_CYCLES cycles. Edges arriving while busy_o is high are ignored completely.
- R10: A pulse on arm_set_i sets arm_o on the next cycle. arm_o clears on the cycle after any accepted edge (enabled, not busy), whatever the mode.
- R11: With cfg_enable_i low, no edge is accepted. Counter, error, flags, snapshots and arm are unaffected.
- R12: With subclass_i high, the edge source is the synchronized external pulse. With subclass_i low, it is the wrap of an internal free-running reference counter, and external pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_i | input | 1 | Raw external alignment pulse |
| subclass_i | input | 1 | 1: external edge source, 0: internal reference |
| cfg_enable_i | input | 1 | Sync processing enable |
| cfg_mode_i | input | 4 | Policy: 4'h1 single shot, 4'h2 continuous, 4'h9 shot then monitor |
| cfg_tol_i | input | 3 | Error window tolerance in clock cycles |
| arm_set_i | input | 1 | One-cycle request to set arm |
| arm_o | output | 1 | Arm state |
| busy_o | output | 1 | Realignment in progress |
| lmfc_cnt_o | output | PERIOD_W | Multiframe counter value |
| lmfc_wrap_o | output | 1 | Counter at its last value |
| cur_err_o | output | 8 | Signed phase error of last check |
| err_lo_o | output | 1 | Error beyond window, low side |
| err_hi_o | output | 1 | Error beyond window, high side |
| snap_err_o | output | 4 | Error low bits captured at realignment |
| snap_lo_o | output | 1 | Low-side flag captured at realignment |
| snap_hi_o | output | 1 | High-side flag captured at realignment |

## Verification
The assertions check several properties on every cycle:

- the counter steps by one except on the cycle a realignment starts;
- a realignment always leaves the counter at 1 with a cleared error and cleared flags;
- the two flags are never set together, and each agrees with the sign of the reported error;
- busy never lasts longer than its configured length;
- nothing rotates while processing is disabled.

Some behaviour can be shown only by bench scenarios. This covers which edges each policy checks or ignores, the exact error values and the flag boundaries at the tolerance edge, and the snapshot contents. It also covers the self-clearing arm, edges falling inside the busy window, and the switch to the internal reference.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int ERR_W  = 8;
  localparam int SNAP_W = 4;
  localparam int MODE_W = 4;
  localparam int TOL_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF     = 4'h0,
    SM_ONESHOT = 4'h1,
    SM_CONT    = 4'h2,
    SM_MONITOR = 4'h9
  } sync_mode_e;
endpackage

// File: rtl/fpa_edge_sync.sv
module fpa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], raw_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fpa_lmfc_counter.sv
module fpa_lmfc_counter #(
  parameter int W      = 5,
  parameter int RELOAD = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] RELOAD_V = W'(RELOAD);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (reload_i) cnt_d = RELOAD_V;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fpa_sync_ctrl.sv
module fpa_sync_ctrl
  import fpa_pkg::*;
#(
  parameter int PERIOD_W    = 5,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_i,
  input  logic                enable_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [TOL_W-1:0]    tol_i,
  input  logic                arm_set_i,
  input  logic [PERIOD_W-1:0] cnt_i,
  output logic                realign_o,
  output logic                arm_o,
  output logic                busy_o,
  output logic [ERR_W-1:0]    cur_err_o,
  output logic                err_lo_o,
  output logic                err_hi_o,
  output logic [SNAP_W-1:0]   snap_err_o,
  output logic                snap_lo_o,
  output logic                snap_hi_o
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  logic [BUSY_W-1:0] busy_q, busy_d;
  logic              arm_q, arm_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              lo_q, lo_d, hi_q, hi_d;
  logic [SNAP_W-1:0] snap_q, snap_d;
  logic              slo_q, slo_d, shi_q, shi_d;

  logic             busy_free, accept, is_one, is_cont, is_mon;
  logic             check, rot_ok, rotate, neg, viol;
  logic [ERR_W-1:0] meas, mag;

  // phase measurement: counter value read as signed offset from the wrap
  always_comb begin
    meas = ERR_W'($signed(cnt_i));
    neg  = meas[ERR_W-1];
    mag  = neg ? (~meas + 1'b1) : meas;
    viol = mag > ERR_W'(tol_i);
  end

  // policy decode
  always_comb begin
    busy_free = (busy_q == '0);
    accept    = enable_i & edge_i & busy_free;
    is_one    = (mode_i == SM_ONESHOT);
    is_cont   = (mode_i == SM_CONT);
    is_mon    = (mode_i == SM_MONITOR);
    check     = accept & (is_cont | is_mon | (is_one & arm_q));
    rot_ok    = is_cont | ((is_one | is_mon) & arm_q);
    rotate    = check & rot_ok & viol;
  end

  // next state
  always_comb begin
    arm_d  = arm_q;
    busy_d = busy_q;
    err_d  = err_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    snap_d = snap_q;
    slo_d  = slo_q;
    shi_d  = shi_q;

    if (arm_set_i)   arm_d = 1'b1;
    else if (accept) arm_d = 1'b0;

    if (rotate)          busy_d = BUSY_LOAD;
    else if (!busy_free) busy_d = busy_q - 1'b1;

    if (rotate) begin
      snap_d = meas[SNAP_W-1:0];
      slo_d  = viol & neg;
      shi_d  = viol & ~neg;
      err_d  = '0;
      lo_d   = 1'b0;
      hi_d   = 1'b0;
    end else if (check) begin
      err_d = meas;
      lo_d  = viol & neg;
      hi_d  = viol & ~neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      busy_q <= '0;
      err_q  <= '0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      snap_q <= '0;
      slo_q  <= 1'b0;
      shi_q  <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      snap_q <= snap_d;
      slo_q  <= slo_d;
      shi_q  <= shi_d;
    end
  end

  assign realign_o  = rotate;
  assign arm_o      = arm_q;
  assign busy_o     = ~busy_free;
  assign cur_err_o  = err_q;
  assign err_lo_o   = lo_q;
  assign err_hi_o   = hi_q;
  assign snap_err_o = snap_q;
  assign snap_lo_o  = slo_q;
  assign snap_hi_o  = shi_q;
endmodule

// File: rtl/frame_phase_align.sv
module frame_phase_align
  import fpa_pkg::*;
#(
  parameter int PERIOD_W    = 5,
  parameter int BUSY_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sysref_i,
  input  logic                subclass_i,
  input  logic                cfg_enable_i,
  input  logic [3:0]          cfg_mode_i,
  input  logic [2:0]          cfg_tol_i,
  input  logic                arm_set_i,
  output logic                arm_o,
  output logic                busy_o,
  output logic [PERIOD_W-1:0] lmfc_cnt_o,
  output logic                lmfc_wrap_o,
  output logic [7:0]          cur_err_o,
  output logic                err_lo_o,
  output logic                err_hi_o,
  output logic [3:0]          snap_err_o,
  output logic                snap_lo_o,
  output logic                snap_hi_o
);
  localparam int RELOAD_VAL = 1;

  logic                ext_rise, ref_pulse, align_edge, realign;
  logic [PERIOD_W-1:0] lmfc_cnt, ref_cnt;

  fpa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (sysref_i),
    .rise_o (ext_rise)
  );

  // internal reference for subclass 0: free-running, never realigned
  fpa_lmfc_counter #(.W(PERIOD_W), .RELOAD(0)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (1'b0),
    .cnt_o    (ref_cnt)
  );

  fpa_lmfc_counter #(.W(PERIOD_W), .RELOAD(RELOAD_VAL)) u_lmfc (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (realign),
    .cnt_o    (lmfc_cnt)
  );

  always_comb begin
    ref_pulse  = &ref_cnt;
    align_edge = subclass_i ? ext_rise : ref_pulse;
  end

  fpa_sync_ctrl #(.PERIOD_W(PERIOD_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (align_edge),
    .enable_i   (cfg_enable_i),
    .mode_i     (cfg_mode_i),
    .tol_i      (cfg_tol_i),
    .arm_set_i  (arm_set_i),
    .cnt_i      (lmfc_cnt),
    .realign_o  (realign),
    .arm_o      (arm_o),
    .busy_o     (busy_o),
    .cur_err_o  (cur_err_o),
    .err_lo_o   (err_lo_o),
    .err_hi_o   (err_hi_o),
    .snap_err_o (snap_err_o),
    .snap_lo_o  (snap_lo_o),
    .snap_hi_o  (snap_hi_o)
  );

  assign lmfc_cnt_o  = lmfc_cnt;
  assign lmfc_wrap_o = &lmfc_cnt;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int PERIOD_W    = 5,
  parameter int BUSY_CYCLES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_enable_i,
  input logic                busy_o,
  input logic [PERIOD_W-1:0] lmfc_cnt_o,
  input logic                lmfc_wrap_o,
  input logic [7:0]          cur_err_o,
  input logic                err_lo_o,
  input logic                err_hi_o
);
  logic [PERIOD_W-1:0] prev_cnt;
  logic                seen_q, prev_en;
  logic [7:0]          brun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cnt <= '0;
      seen_q   <= 1'b0;
      prev_en  <= 1'b0;
      brun     <= '0;
    end else begin
      prev_cnt <= lmfc_cnt_o;
      seen_q   <= 1'b1;
      prev_en  <= cfg_enable_i;
      if (!busy_o)          brun <= '0;
      else if (brun != '1)  brun <= brun + 1'b1;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$rose(busy_o)) |-> (lmfc_cnt_o == PERIOD_W'(prev_cnt + 1'b1)));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lmfc_wrap_o |-> (lmfc_cnt_o == '1));

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_lo_o && err_hi_o));

  assert_flag_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lo_o |-> cur_err_o[7]) and (err_hi_o |-> !cur_err_o[7]));

  assert_realign_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (lmfc_cnt_o == PERIOD_W'(1) && cur_err_o == 8'd0 && !err_lo_o && !err_hi_o));

  assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(brun) <= BUSY_CYCLES);

  assert_disabled_no_rotate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !prev_en) |-> !$rose(busy_o));
endmodule

bind frame_phase_align fpa_checker #(.PERIOD_W(PERIOD_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable_i (cfg_enable_i),
  .busy_o       (busy_o),
  .lmfc_cnt_o   (lmfc_cnt_o),
  .lmfc_wrap_o  (lmfc_wrap_o),
  .cur_err_o    (cur_err_o),
  .err_lo_o     (err_lo_o),
  .err_hi_o     (err_hi_o)
);

// File: tb/frame_phase_align_tb.sv
module frame_phase_align_tb;
  localparam int PW = 5;
  localparam int P  = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sysref = 1'b0, subclass = 1'b1, en = 1'b0, arm_set = 1'b0;
  logic [3:0] mode = 4'h0;
  logic [2:0] tol = 3'd0;
  logic arm, busy, wrap, elo, ehi, slo, shi;
  logic [PW-1:0] cnt;
  logic [7:0] cerr;
  logic [3:0] serr;

  int n_chk = 0, n_fail = 0;
  int m_arm = 0, m_err = 0, m_lo = 0, m_hi = 0, m_snap = 0, m_slo = 0, m_shi = 0;

  frame_phase_align #(.PERIOD_W(PW), .BUSY_CYCLES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sysref_i(sysref), .subclass_i(subclass),
    .cfg_enable_i(en), .cfg_mode_i(mode), .cfg_tol_i(tol), .arm_set_i(arm_set),
    .arm_o(arm), .busy_o(busy), .lmfc_cnt_o(cnt), .lmfc_wrap_o(wrap),
    .cur_err_o(cerr), .err_lo_o(elo), .err_hi_o(ehi),
    .snap_err_o(serr), .snap_lo_o(slo), .snap_hi_o(shi)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_err(input int c);
    return (c < P/2) ? c : c - P;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic do_arm();
    @(negedge clk); arm_set = 1'b1;
    @(negedge clk); arm_set = 1'b0;
    m_arm = 1;
    check("R10 arm set", int'(arm), 1);
  endtask

  // one external pulse; target >= 0 places the checked counter value
  task automatic edge_and_check(input int target);
    int c, e, viol, acc, one, cont, mon, chk, rok, rot;
    bit b;
    string tag;
    @(negedge clk);
    if (target >= 0) while (int'(cnt) != (target + P - 2) % P) @(negedge clk);
    sysref = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    c = int'(cnt); b = busy;
    sysref = 1'b0;
    @(negedge clk);
    e    = exp_err(c);
    viol = (iabs(e) > int'(tol));
    acc  = en && !b;
    one  = (mode == 4'h1); cont = (mode == 4'h2); mon = (mode == 4'h9);
    chk  = acc && (cont || mon || (one && m_arm));
    rok  = cont || ((one || mon) && m_arm);
    rot  = chk && rok && viol;
    if (!en)       tag = "R11";
    else if (b)    tag = "R9";
    else if (one)  tag = "R6";
    else if (cont) tag = "R7";
    else if (mon)  tag = "R8";
    else           tag = "R10";
    if (rot) begin
      m_snap = e & 15; m_slo = (e < 0); m_shi = (e > 0);
      m_err = 0; m_lo = 0; m_hi = 0;
    end else if (chk) begin
      m_err = e & 255; m_lo = viol && (e < 0); m_hi = viol && (e > 0);
    end
    if (acc) m_arm = 0;
    check({"R4 counter ", tag}, int'(cnt), rot ? 1 : (c + 1) % P);
    check({"R3 error ", tag}, int'(cerr), m_err);
    check({"R3 low flag ", tag}, int'(elo), m_lo);
    check({"R3 high flag ", tag}, int'(ehi), m_hi);
    check({"R5 snapshot ", tag}, int'(serr), m_snap);
    check({"R5 snap flags ", tag}, int'({slo, shi}), m_slo * 2 + m_shi);
    check({"R10 arm ", tag}, int'(arm), m_arm);
    check({"R9 busy ", tag}, int'(busy), rot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed, prev, ok;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 reset cnt", int'(cnt), 0);
    check("R1 reset status", int'({arm, busy, elo, ehi, slo, shi}), 0);
    check("R1 reset err", int'(cerr) + int'(serr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset cnt", int'(cnt), 1);
    for (int i = 0; i < 40; i++) begin
      prev = int'(cnt);
      @(negedge clk);
      check("R2 step", int'(cnt), (prev + 1) % P);
      check("R2 wrap", int'(wrap), int'(cnt) == P - 1);
    end
    // R11 directed: disabled
    en = 1'b0; mode = 4'h2; tol = 3'd0; edge_and_check(9);
    // R7 directed: continuous without arm, boundary cases at tolerance 7
    en = 1'b1; tol = 3'd7;
    edge_and_check(7);
    edge_and_check(8);
    edge_and_check(P - 7);
    edge_and_check(P - 8);
    // R9: edge right after a rotation falls in busy window
    tol = 3'd0; edge_and_check(12); edge_and_check(-1);
    // R6: single shot, armed then unarmed edges
    mode = 4'h1; do_arm(); edge_and_check(5); edge_and_check(20); edge_and_check(3);
    // R8: shot then monitor
    mode = 4'h9; tol = 3'd1; do_arm(); edge_and_check(P - 3); edge_and_check(6); edge_and_check(1);
    // R7: arming in continuous has no other effect
    mode = 4'h2; do_arm(); edge_and_check(4); edge_and_check(2);
    // constrained random mix
    for (int i = 0; i < 250; i++) begin
      int r;
      r = $urandom_range(0, 9);
      mode = (r < 3) ? 4'h1 : (r < 6) ? 4'h2 : (r < 9) ? 4'h9 : 4'h0;
      tol  = 3'($urandom_range(0, 7));
      en   = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 9) < 3) do_arm();
      repeat ($urandom_range(0, 2 * P)) @(negedge clk);
      edge_and_check($urandom_range(0, 3) == 0 ? int'($urandom_range(0, P - 1)) : -1);
    end
    // R12: subclass 0 follows internal reference; first leave a nonzero error
    en = 1'b1; mode = 4'h9; tol = 3'd0; m_arm = 0;
    @(negedge clk); while (busy) @(negedge clk);
    edge_and_check(6);
    check("R12 nonzero before", int'(cerr != 8'd0), 1);
    mode = 4'h2; subclass = 1'b0;
    repeat (3 * P) @(negedge clk);
    check("R12 internal aligned err", int'(cerr), 0);
    check("R12 internal aligned flags", int'({elo, ehi}), 0);
    ok = 1;
    repeat (2 * P) begin
      @(negedge clk);
      if (busy) ok = 0;
    end
    check("R12 stays aligned", ok, 1);
    prev = -1;
    @(negedge clk); while (int'(cnt) != 8) @(negedge clk);
    sysref = 1'b1; repeat (4) @(negedge clk); sysref = 1'b0;
    check("R12 external ignored cnt", int'(cnt), 12);
    check("R12 external ignored err", int'(cerr), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule